// File: doc/BRIEF.md
# Byte-Wide Data Memory Router for an 8-bit Microcontroller Core

This block sits between an 8-bit microcontroller core and its data storage. For every byte access the core presents an address, an access mode and an optional stack marker. The block then sends the access to one of three places: a 256-byte internal scratch RAM, an external special-function-register (SFR) file, or a 256-byte on-chip expanded RAM. All read results come back to the core on one registered read-data path. Both RAM arrays are held inside the block. The SFR file is reached through a simple read/write strobe port.

Numeric addresses 80h to FFh can mean two different targets. Direct-mode accesses in that range go to the SFR port. Indirect-mode accesses go to the upper half of the scratch RAM. Expanded-RAM accesses use either an 8-bit pointer or a 16-bit pointer. Only 16-bit addresses 0000h to 00FFh map onto the on-chip array. Outside that window a write is dropped, and a read returns a fixed zero together with a flag. A legacy disable input for the expanded RAM is accepted but ignored. Stack accesses always use the scratch RAM.

Top module: `dmem_router`

## Requirements
- R1: Mode code 0 (direct) and mode code 1 (indirect) with address bits [7:0] in 00h..7Fh reach the same scratch-RAM byte, whichever mode wrote it.
- R2: Mode 1 (indirect) with address bits [7:0] in 80h..FFh reaches the upper scratch-RAM byte at that index, and it never raises `sfr_re` or `sfr_we`.
- R3: Mode 0 (direct) with bit 7 of the address set raises `sfr_we` (write) or `sfr_re` (read) in the request cycle, with `sfr_addr` = address[7:0] and `sfr_wdata` = the write data. The scratch RAM is not changed. A direct read returns the `sfr_rdata` value sampled in the request cycle.
- R4: Mode 2 (8-bit pointer) reaches the expanded-RAM byte at address[7:0], whatever address[15:8] holds. The expanded RAM is a separate array from the scratch RAM.
- R5: Mode 3 (16-bit pointer) with address 0000h..00FFh reaches the same expanded-RAM byte as mode 2 with the same low byte.
- R6: A mode 3 write with address 0100h..FFFFh changes neither RAM and raises no SFR strobe.
- R7: A mode 3 read with address 0100h..FFFFh returns 00h with `rd_undef` = 1. Every other read returns `rd_undef` = 0.
- R8: The `xram_off` input has no effect. Expanded-RAM reads and writes behave the same for either value.
- R9: Expanded-RAM accesses (modes 2 and 3) never raise `sfr_re` or `sfr_we`.
- R10: With `req_stack` = 1, an access always goes to the scratch-RAM byte at address[7:0], whatever the mode. It never goes to the expanded RAM and never raises an SFR strobe.
- R11: A write takes effect on the rising clock edge where `req_valid` and `req_we` are both high. A read request gives `rvalid` = 1 and its data on `rdata` for exactly the cycle after the request. `rdata` holds that value until the next read.
- R12: Synchronous reset clears `rvalid`, `rd_undef` and `rdata` to zero. RAM contents are kept across reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_we | input | 1 | 1 = write, 0 = read |
| req_mode | input | 2 | 0 direct, 1 indirect, 2 expanded 8-bit pointer, 3 expanded 16-bit pointer |
| req_stack | input | 1 | Stack access; forces the scratch RAM |
| req_addr | input | 16 | Byte address (only the low byte is used except in mode 3) |
| req_wdata | input | 8 | Write data |
| xram_off | input | 1 | Legacy expanded-RAM disable bit, ignored |
| rdata | output | 8 | Registered read data |
| rvalid | output | 1 | High in the cycle after a read request |
| rd_undef | output | 1 | Read hit the unmapped 16-bit window |
| sfr_re | output | 1 | SFR read strobe |
| sfr_we | output | 1 | SFR write strobe |
| sfr_addr | output | 8 | SFR register index |
| sfr_wdata | output | 8 | SFR write data |
| sfr_rdata | input | 8 | SFR read data, valid in the strobe cycle |

## Verification
The same low address byte is written and read under every access mode. This shows whether the three targets are really separate: a value in the scratch RAM at 90h must not show up through the SFR port or the expanded RAM, and the reverse. Address patterns with junk in the high byte under the 8-bit pointer, compared with the same byte under a 16-bit pointer inside and outside 0000h..00FFh, separate correct window decoding from plain truncation. Stack-marked accesses in the direct and 16-bit modes show whether the stack override takes priority over the mode. A write before reset, read back after reset, shows whether the arrays are kept.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    localparam int ADDR_W = 16;
    localparam int DATA_W = 8;
    localparam int IDX_W  = 8;
    localparam int UPPER_BIT = IDX_W - 1;

    typedef enum logic [1:0] {
        AM_DIRECT   = 2'd0,
        AM_INDIRECT = 2'd1,
        AM_XPTR8    = 2'd2,
        AM_XPTR16   = 2'd3
    } acc_mode_e;

    typedef enum logic [1:0] {
        TGT_IRAM = 2'd0,
        TGT_SFR  = 2'd1,
        TGT_XRAM = 2'd2,
        TGT_NONE = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [IDX_W-1:0]  idx;
    } route_t;

    // Priority: stack marker first, then access mode.
    function automatic route_t route_of(acc_mode_e m, logic stk,
                                        logic [ADDR_W-1:0] a);
        route_t r;
        r.idx = a[IDX_W-1:0];
        if (stk) begin
            r.tgt = TGT_IRAM;
        end else begin
            unique case (m)
                AM_DIRECT:   r.tgt = a[UPPER_BIT] ? TGT_SFR : TGT_IRAM;
                AM_INDIRECT: r.tgt = TGT_IRAM;
                AM_XPTR8:    r.tgt = TGT_XRAM;
                default:     r.tgt = (a[ADDR_W-1:IDX_W] == '0) ? TGT_XRAM
                                                                : TGT_NONE;
            endcase
        end
        return r;
    endfunction

endpackage

// File: rtl/dmem_route.sv
module dmem_route
    import dmem_pkg::*;
(
    input  logic              req_valid,
    input  logic              req_we,
    input  acc_mode_e         req_mode,
    input  logic              req_stack,
    input  logic [ADDR_W-1:0] req_addr,
    output route_t            rt,
    output logic              rd_req,
    output logic              iram_we,
    output logic              iram_re,
    output logic              xram_we,
    output logic              xram_re,
    output logic              sfr_we,
    output logic              sfr_re
);
    logic wr, rd;

    always_comb begin
        rt      = route_of(req_mode, req_stack, req_addr);
        wr      = req_valid &&  req_we;
        rd      = req_valid && !req_we;
        rd_req  = rd;
        iram_we = wr && (rt.tgt == TGT_IRAM);
        iram_re = rd && (rt.tgt == TGT_IRAM);
        xram_we = wr && (rt.tgt == TGT_XRAM);
        xram_re = rd && (rt.tgt == TGT_XRAM);
        sfr_we  = wr && (rt.tgt == TGT_SFR);
        sfr_re  = rd && (rt.tgt == TGT_SFR);
    end
endmodule

// File: rtl/dmem_bank.sv
module dmem_bank #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 8,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              we,
    input  logic              re,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Contents are never reset; only the write port changes them.
    always_ff @(posedge clk) begin
        if (we) mem[idx] <= wdata;
        if (re) rdata    <= mem[idx];
    end
endmodule

// File: rtl/dmem_rdmux.sv
module dmem_rdmux
    import dmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_req,
    input  tgt_e              tgt,
    input  logic [DATA_W-1:0] iram_q,
    input  logic [DATA_W-1:0] xram_q,
    input  logic [DATA_W-1:0] sfr_rdata,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              rd_undef
);
    tgt_e              sel_q;
    logic [DATA_W-1:0] sfr_q;
    logic              valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= TGT_NONE;
            sfr_q   <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd_req;
            if (rd_req) begin
                sel_q <= tgt;
                if (tgt == TGT_SFR) sfr_q <= sfr_rdata;
            end
        end
    end

    always_comb begin
        unique case (sel_q)
            TGT_IRAM: rdata = iram_q;
            TGT_XRAM: rdata = xram_q;
            TGT_SFR:  rdata = sfr_q;
            default:  rdata = '0;
        endcase
        rvalid   = valid_q;
        rd_undef = valid_q && (sel_q == TGT_NONE);
    end
endmodule

// File: rtl/dmem_router.sv
module dmem_router
    import dmem_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_we,
    input  logic [1:0]        req_mode,
    input  logic              req_stack,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              xram_off,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              rd_undef,
    output logic              sfr_re,
    output logic              sfr_we,
    output logic [IDX_W-1:0]  sfr_addr,
    output logic [DATA_W-1:0] sfr_wdata,
    input  logic [DATA_W-1:0] sfr_rdata
);
    route_t            rt;
    logic              rd_req;
    logic              iram_we, iram_re, xram_we, xram_re;
    logic [DATA_W-1:0] iram_q, xram_q;
    logic              unused_xram_off;

    // The disable bit is deliberately not wired to anything.
    assign unused_xram_off = xram_off;

    dmem_route u_route (
        .req_valid (req_valid),
        .req_we    (req_we),
        .req_mode  (acc_mode_e'(req_mode)),
        .req_stack (req_stack),
        .req_addr  (req_addr),
        .rt        (rt),
        .rd_req    (rd_req),
        .iram_we   (iram_we),
        .iram_re   (iram_re),
        .xram_we   (xram_we),
        .xram_re   (xram_re),
        .sfr_we    (sfr_we),
        .sfr_re    (sfr_re)
    );

    dmem_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_iram (
        .clk   (clk),
        .we    (iram_we),
        .re    (iram_re),
        .idx   (rt.idx),
        .wdata (req_wdata),
        .rdata (iram_q)
    );

    dmem_bank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_xram (
        .clk   (clk),
        .we    (xram_we),
        .re    (xram_re),
        .idx   (rt.idx),
        .wdata (req_wdata),
        .rdata (xram_q)
    );

    dmem_rdmux u_rdmux (
        .clk       (clk),
        .rst       (rst),
        .rd_req    (rd_req),
        .tgt       (rt.tgt),
        .iram_q    (iram_q),
        .xram_q    (xram_q),
        .sfr_rdata (sfr_rdata),
        .rdata     (rdata),
        .rvalid    (rvalid),
        .rd_undef  (rd_undef)
    );

    assign sfr_addr  = rt.idx;
    assign sfr_wdata = req_wdata;
endmodule

// File: rtl/dmem_router_chk.sv
module dmem_router_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_we,
    input logic [1:0]  req_mode,
    input logic        req_stack,
    input logic [15:0] req_addr,
    input logic [7:0]  rdata,
    input logic        rvalid,
    input logic        rd_undef,
    input logic        sfr_re,
    input logic        sfr_we
);
    // R2
    indirect_no_sfr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 2'd1) |-> (!sfr_re && !sfr_we));

    // R3
    direct_hi_sfr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_stack && req_mode == 2'd0 && req_addr[7])
            |-> (req_we ? sfr_we : sfr_re));

    // R9
    xram_no_sfr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode[1]) |-> (!sfr_re && !sfr_we));

    // R10
    stack_no_sfr_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_stack) |-> (!sfr_re && !sfr_we));

    // R7
    oor_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we && !req_stack && req_mode == 2'd3
            && req_addr[15:8] != 8'h00) |=> (rd_undef && rdata == 8'h00));

    // R11
    read_valid_next_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_we) |=> rvalid);

    // R11
    no_read_no_valid_chk: assert property (@(posedge clk) disable iff (rst)
        !(req_valid && !req_we) |=> !rvalid);

    // R12
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!rvalid && !rd_undef && rdata == 8'h00));

    // R3
    sfr_strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sfr_re, sfr_we}));
endmodule

bind dmem_router dmem_router_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_we    (req_we),
    .req_mode  (req_mode),
    .req_stack (req_stack),
    .req_addr  (req_addr),
    .rdata     (rdata),
    .rvalid    (rvalid),
    .rd_undef  (rd_undef),
    .sfr_re    (sfr_re),
    .sfr_we    (sfr_we)
);

// File: tb/test_dmem_router.sv
module test_dmem_router;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_we = 1'b0;
    logic [1:0]  req_mode = 2'd0;
    logic        req_stack = 1'b0;
    logic [15:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        xram_off = 1'b0;
    logic [7:0]  rdata;
    logic        rvalid, rd_undef, sfr_re, sfr_we;
    logic [7:0]  sfr_addr, sfr_wdata, sfr_rdata;

    int checks = 0;
    int errors = 0;
    int sfr_hits = 0;
    logic [7:0] sfr_file [256];

    localparam logic [1:0] M_DIR = 2'd0, M_IND = 2'd1, M_X8 = 2'd2, M_X16 = 2'd3;

    always #5ns clk = ~clk;

    dmem_router i_dmem_router (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_we(req_we),
        .req_mode(req_mode), .req_stack(req_stack), .req_addr(req_addr),
        .req_wdata(req_wdata), .xram_off(xram_off), .rdata(rdata),
        .rvalid(rvalid), .rd_undef(rd_undef), .sfr_re(sfr_re), .sfr_we(sfr_we),
        .sfr_addr(sfr_addr), .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
    );

    // External SFR file model
    assign sfr_rdata = sfr_file[sfr_addr];
    always @(posedge clk) begin
        if (sfr_we) sfr_file[sfr_addr] <= sfr_wdata;
        if (sfr_re || sfr_we) sfr_hits <= sfr_hits + 1;
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [1:0] m, logic stk, logic [15:0] a, logic [7:0] d);
        req_valid = 1'b1; req_we = 1'b1; req_mode = m; req_stack = stk;
        req_addr = a; req_wdata = d;
        @(posedge clk); #1ns;
        req_valid = 1'b0; req_we = 1'b0; req_stack = 1'b0;
    endtask

    task automatic rd(logic [1:0] m, logic stk, logic [15:0] a,
                      output logic [7:0] d, output logic u);
        req_valid = 1'b1; req_we = 1'b0; req_mode = m; req_stack = stk;
        req_addr = a;
        @(posedge clk); #1ns;
        req_valid = 1'b0; req_stack = 1'b0;
        @(negedge clk);
        check("R11 rvalid after read", rvalid, 1'b1);
        d = rdata; u = rd_undef;
    endtask

    task automatic t_reset();
        check("R12 rvalid at reset", rvalid, 1'b0);
        check("R12 rd_undef at reset", rd_undef, 1'b0);
        check("R12 rdata at reset", rdata, 8'h00);
    endtask

    task automatic t_lower();
        logic [7:0] d; logic u;
        wr(M_DIR, 0, 16'h0012, 8'hA5);
        rd(M_IND, 0, 16'h0012, d, u);
        check("R1 direct write indirect read", d, 8'hA5);
        check("R7 undef low on normal read", u, 1'b0);
        wr(M_IND, 0, 16'h007F, 8'h3C);
        rd(M_DIR, 0, 16'h007F, d, u);
        check("R1 indirect write direct read", d, 8'h3C);
    endtask

    task automatic t_upper();
        logic [7:0] d; logic u; int h0;
        sfr_file[8'h90] = 8'h00;
        h0 = sfr_hits;
        wr(M_IND, 0, 16'h0090, 8'h5A);
        rd(M_IND, 0, 16'h0090, d, u);
        check("R2 upper RAM readback", d, 8'h5A);
        check("R2 no SFR strobe", sfr_hits, h0);
        check("R2 SFR file untouched", sfr_file[8'h90], 8'h00);
        wr(M_DIR, 0, 16'h0090, 8'hC3);
        check("R3 SFR write seen", sfr_file[8'h90], 8'hC3);
        rd(M_IND, 0, 16'h0090, d, u);
        check("R3 upper RAM unchanged by SFR write", d, 8'h5A);
        rd(M_DIR, 0, 16'h0090, d, u);
        check("R3 SFR read data", d, 8'hC3);
        check("R3 SFR strobe count", sfr_hits, h0 + 2);
    endtask

    task automatic t_xram();
        logic [7:0] d; logic u; int h0;
        h0 = sfr_hits;
        wr(M_X8, 0, 16'hAB12, 8'h77);
        rd(M_X16, 0, 16'h0012, d, u);
        check("R5 16-bit pointer sees 8-bit write", d, 8'h77);
        rd(M_X8, 0, 16'h5512, d, u);
        check("R4 high byte ignored", d, 8'h77);
        rd(M_IND, 0, 16'h0012, d, u);
        check("R4 scratch RAM separate", d, 8'hA5);
        check("R9 no SFR strobe on xram", sfr_hits, h0);
    endtask

    task automatic t_window();
        logic [7:0] d; logic u; int h0;
        h0 = sfr_hits;
        wr(M_X16, 0, 16'h0112, 8'hEE);
        wr(M_X16, 0, 16'hFF90, 8'hEE);
        rd(M_X16, 0, 16'h0012, d, u);
        check("R6 xram unchanged", d, 8'h77);
        rd(M_IND, 0, 16'h0012, d, u);
        check("R6 scratch low unchanged", d, 8'hA5);
        rd(M_IND, 0, 16'h0090, d, u);
        check("R6 scratch high unchanged", d, 8'h5A);
        check("R6 no SFR strobe", sfr_hits, h0);
        rd(M_X16, 0, 16'h0112, d, u);
        check("R7 out-of-window data", d, 8'h00);
        check("R7 out-of-window flag", u, 1'b1);
        rd(M_X16, 0, 16'h00FF, d, u);
        check("R7 in-window flag clear", u, 1'b0);
    endtask

    task automatic t_disable();
        logic [7:0] d; logic u;
        xram_off = 1'b1;
        wr(M_X8, 0, 16'h0040, 8'h99);
        rd(M_X16, 0, 16'h0040, d, u);
        check("R8 xram works with disable bit set", d, 8'h99);
        xram_off = 1'b0;
        rd(M_X8, 0, 16'h0040, d, u);
        check("R8 data same with bit clear", d, 8'h99);
    endtask

    task automatic t_stack();
        logic [7:0] d; logic u; int h0;
        wr(M_X8, 0, 16'h00C0, 8'h22);
        h0 = sfr_hits;
        wr(M_X16, 1, 16'h00C0, 8'h11);
        rd(M_IND, 0, 16'h00C0, d, u);
        check("R10 stack write lands in scratch RAM", d, 8'h11);
        rd(M_X8, 0, 16'h00C0, d, u);
        check("R10 xram untouched by stack", d, 8'h22);
        wr(M_DIR, 1, 16'h0085, 8'h66);
        rd(M_DIR, 1, 16'h0085, d, u);
        check("R10 stack pop from upper RAM", d, 8'h66);
        check("R10 no SFR strobe on stack", sfr_hits, h0);
    endtask

    task automatic t_timing();
        logic [7:0] d; logic u;
        rd(M_IND, 0, 16'h0012, d, u);
        @(negedge clk);
        check("R11 rvalid one cycle only", rvalid, 1'b0);
        check("R11 rdata held", rdata, 8'hA5);
        wr(M_IND, 0, 16'h0013, 8'h42);
        @(negedge clk);
        check("R11 no rvalid on write", rvalid, 1'b0);
        rd(M_IND, 0, 16'h0013, d, u);
        check("R11 write visible next cycle", d, 8'h42);
    endtask

    task automatic t_reset_keep();
        logic [7:0] d; logic u;
        rst = 1'b1;
        @(posedge clk); #1ns;
        rst = 1'b0;
        @(negedge clk);
        check("R12 rdata cleared", rdata, 8'h00);
        rd(M_IND, 0, 16'h0090, d, u);
        check("R12 scratch RAM kept", d, 8'h5A);
        rd(M_X8, 0, 16'h0012, d, u);
        check("R12 xram kept", d, 8'h77);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) sfr_file[i] = 8'h00;
        repeat (3) @(posedge clk);
        #1ns rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lower();
        t_upper();
        t_xram();
        t_window();
        t_disable();
        t_stack();
        t_timing();
        t_reset_keep();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #100us;
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule